// File: doc/BRIEF.md
# Cache Block Transfer Order Sequencer

This block works out the order in which the doublewords of a cache line cross a multiplexed address/data system bus during a block transfer. A request carries the byte address that missed (or the line being evicted), a block length of four or eight doublewords, and a read/write flag. The sequencer captures the request, produces the single address that goes on the bus in the address phase, and then steps a doubleword index once for every data beat that the bus logic accepts. It raises a flag on the final beat and returns to idle once that beat is taken.

Writes always go out in ascending order from the first doubleword of the line. For reads, the ordering is set once during boot. In linear order the bus sees the line's base address and data comes back from doubleword 0 upward. In interleaved order the bus sees the address of the doubleword that was actually needed. Data then comes back with that doubleword first, and each later index is the starting index XOR the beat number. Linear read order depends on a secondary cache being present. If that cache is missing at boot, interleaved order is forced.

Top module: `blk_xfer_seq`

## Requirements
- R1: After synchronous reset, `busy`, `last_beat`, `dw_idx` and `bus_addr` are all zero, and the read order is interleaved until a boot load is accepted.
- R2: The read order is taken from `boot_linear` on the first cycle after reset in which `boot_load` is high. Any later `boot_load` pulse before the next reset has no effect.
- R3: Linear read order is latched only if `l2_present` is high in that same cycle. Otherwise interleaved order is latched, even when `boot_linear` is high.
- R4: For a write (`req_write`=1), `bus_addr` is the request address with its low 5 bits cleared (4-doubleword line) or its low 6 bits cleared (8-doubleword line). `dw_idx` runs 0, 1, … up to length-1, whatever read order was latched.
- R5: For a read in linear order, `bus_addr` and the `dw_idx` sequence follow the same rule as R4.
- R6: For a read in interleaved order, `bus_addr` is the request address with its low 3 bits cleared. On beat n, `dw_idx` equals s XOR n, where s is bits [4:3] of the request address (4-doubleword line) or bits [5:3] (8-doubleword line).
- R7: `req_blk8`=1 selects an 8-beat transfer and `req_blk8`=0 selects a 4-beat transfer.
- R8: `last_beat` is high only while busy and on the final beat. When `beat_adv` is high on that beat, `busy` is low in the next cycle.
- R9: A request (`req_valid` high) that arrives while `busy` is high is ignored. `bus_addr` and the index sequence of the transfer in progress are unchanged, and no second transfer starts.
- R10: `dw_idx` moves to the next beat only in a cycle in which `beat_adv` is high. In all other cycles it holds.
- R11: A request accepted while idle makes `busy` high in the following cycle, with `bus_addr` valid and `dw_idx` showing beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_load | input | 1 | Boot-time strobe that latches the read order |
| boot_linear | input | 1 | Requested read order at boot: 1 linear, 0 interleaved |
| l2_present | input | 1 | High when a secondary cache is fitted |
| req_valid | input | 1 | Block transfer request strobe |
| req_write | input | 1 | 1 block write, 0 block read |
| req_blk8 | input | 1 | 1 eight-doubleword line, 0 four-doubleword line |
| req_addr | input | ADDR_W | Byte address of the requested doubleword |
| beat_adv | input | 1 | The current data beat is accepted |
| busy | output | 1 | Transfer in progress |
| bus_addr | output | ADDR_W | Address to place on the bus for this transfer |
| dw_idx | output | 3 | Doubleword index within the line for the current beat |
| last_beat | output | 1 | Current beat is the final one |

## Verification
Several properties are checked on every cycle by the assertions. The index and the bus address hold during stalls and while a transfer is in progress. The last-beat flag never appears while idle, and the transfer always ends after the final beat is accepted. The latched order never changes once loaded, and linear order is never latched without the secondary cache present. Some behaviour can only be shown by the bench scenarios: the actual index permutations for each order and line length, the aligned addresses, the way a boot configuration decides the read order, and the fact that a request arriving mid-transfer leaves the running sequence intact. The bench shows these by comparing every beat against a queue of expected items.

// File: rtl/bxs_pkg.sv
package bxs_pkg;

    localparam int DW_OFS   = 3;              // byte offset bits of a doubleword
    localparam int LG_SHORT = 2;              // log2 of short line length
    localparam int LG_LONG  = 3;              // log2 of long line length
    localparam int IDX_W    = LG_LONG;

    typedef enum logic {
        ORD_XOR    = 1'b0,
        ORD_LINEAR = 1'b1
    } ord_e;

    typedef struct packed {
        ord_e             ord;
        logic             lg8;
        logic [IDX_W-1:0] start;
    } xfer_s;

    function automatic logic [IDX_W-1:0] last_idx(input logic lg8);
        return lg8 ? IDX_W'((1 << LG_LONG) - 1) : IDX_W'((1 << LG_SHORT) - 1);
    endfunction

    function automatic int unsigned line_bits(input logic lg8);
        return lg8 ? DW_OFS + LG_LONG : DW_OFS + LG_SHORT;
    endfunction

endpackage

// File: rtl/bxs_mode_latch.sv
module bxs_mode_latch
    import bxs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic want_linear,
    input  logic l2_present,
    output ord_e read_ord,
    output logic locked
);
    always_ff @(posedge clk) begin
        if (rst) begin
            read_ord <= ORD_XOR;
            locked   <= 1'b0;
        end else if (load && !locked) begin
            read_ord <= (want_linear && l2_present) ? ORD_LINEAR : ORD_XOR;
            locked   <= 1'b1;
        end
    end
endmodule

// File: rtl/bxs_beat_ctr.sv
module bxs_beat_ctr
    import bxs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             lg8,
    input  logic             adv,
    output logic             busy,
    output logic [IDX_W-1:0] beat,
    output logic             last
);
    assign last = busy && (beat == last_idx(lg8));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            beat <= '0;
        end else if (start) begin
            busy <= 1'b1;
            beat <= '0;
        end else if (busy && adv) begin
            if (last) begin
                busy <= 1'b0;
                beat <= '0;
            end else begin
                beat <= beat + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bxs_index_gen.sv
module bxs_index_gen
    import bxs_pkg::*;
(
    input  xfer_s            xfer,
    input  logic [IDX_W-1:0] beat,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        unique case (xfer.ord)
            ORD_LINEAR: idx = beat;
            ORD_XOR:    idx = (xfer.start ^ beat) & last_idx(xfer.lg8);
            default:    idx = beat;
        endcase
    end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import bxs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_load,
    input  logic              boot_linear,
    input  logic              l2_present,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_blk8,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              beat_adv,
    output logic              busy,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [IDX_W-1:0]  dw_idx,
    output logic              last_beat
);
    ord_e             read_ord;
    logic             mode_locked;
    logic             start;
    logic [IDX_W-1:0] beat;
    logic [IDX_W-1:0] gen_idx;
    xfer_s            xfer_q;
    xfer_s            xfer_d;
    logic [ADDR_W-1:0] addr_d;
    logic [ADDR_W-1:0] line_mask;
    logic [ADDR_W-1:0] dw_mask;

    assign start = req_valid && !busy;

    bxs_mode_latch mode_i (
        .clk        (clk),
        .rst        (rst),
        .load       (boot_load),
        .want_linear(boot_linear),
        .l2_present (l2_present),
        .read_ord   (read_ord),
        .locked     (mode_locked)
    );

    bxs_beat_ctr ctr_i (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .lg8  (xfer_q.lg8),
        .adv  (beat_adv),
        .busy (busy),
        .beat (beat),
        .last (last_beat)
    );

    bxs_index_gen gen_i (
        .xfer(xfer_q),
        .beat(beat),
        .idx (gen_idx)
    );

    always_comb begin
        line_mask = ~((ADDR_W'(1) << line_bits(req_blk8)) - ADDR_W'(1));
        dw_mask   = ~((ADDR_W'(1) << DW_OFS) - ADDR_W'(1));
        xfer_d.ord   = req_write ? ORD_LINEAR : read_ord;
        xfer_d.lg8   = req_blk8;
        xfer_d.start = req_addr[DW_OFS +: IDX_W] & last_idx(req_blk8);
        addr_d = (xfer_d.ord == ORD_LINEAR) ? (req_addr & line_mask)
                                            : (req_addr & dw_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_q   <= '0;
            bus_addr <= '0;
        end else if (start) begin
            xfer_q   <= xfer_d;
            bus_addr <= addr_d;
        end
    end

    assign dw_idx = busy ? gen_idx : '0;
endmodule

// File: rtl/bxs_chk.sv
module bxs_chk
    import bxs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              last_beat,
    input logic              beat_adv,
    input logic [IDX_W-1:0]  dw_idx,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              l2_present,
    input ord_e              read_ord,
    input logic              mode_locked
);
    p_last_needs_busy_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !last_beat);

    p_ends_after_last_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && last_beat && beat_adv) |=> !busy);

    p_idx_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !beat_adv) |=> (busy && $stable(dw_idx)));

    p_addr_steady_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !(last_beat && beat_adv)) |=> $stable(bus_addr));

    p_order_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        mode_locked |=> (mode_locked && $stable(read_ord)));

    p_linear_needs_l2_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(mode_locked) && read_ord == ORD_LINEAR) |-> $past(l2_present));
endmodule

bind blk_xfer_seq bxs_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .last_beat  (last_beat),
    .beat_adv   (beat_adv),
    .dw_idx     (dw_idx),
    .bus_addr   (bus_addr),
    .l2_present (l2_present),
    .read_ord   (read_ord),
    .mode_locked(mode_locked)
);

// File: tb/blk_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module blk_xfer_seq_tb_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          boot_load = 1'b0, boot_linear = 1'b0, l2_present = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_blk8 = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          beat_adv = 1'b0;
    logic          busy, last_beat;
    logic [AW-1:0] bus_addr;
    logic [2:0]    dw_idx;

    int  vectors = 0;
    int  errors  = 0;
    bit  done    = 1'b0;
    bit  exp_linear = 1'b0;
    bit  exp_locked = 1'b0;

    typedef struct {
        logic [AW-1:0] a;
        logic [2:0]    i;
        logic          l;
        string         r;
    } item_t;
    item_t q[$];

    always #2 clk = ~clk;   // 250 MHz

    blk_xfer_seq #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .boot_load(boot_load), .boot_linear(boot_linear),
        .l2_present(l2_present), .req_valid(req_valid), .req_write(req_write),
        .req_blk8(req_blk8), .req_addr(req_addr), .beat_adv(beat_adv),
        .busy(busy), .bus_addr(bus_addr), .dw_idx(dw_idx), .last_beat(last_beat)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: compare the front of the queue every cycle while busy
    always @(negedge clk) begin
        if (!rst && busy) begin
            if (q.size() == 0) begin
                check(1'b0, "R9", 64'(busy), 64'd0);
            end else begin
                check(bus_addr == q[0].a, q[0].r, 64'(bus_addr), 64'(q[0].a));
                check(dw_idx == q[0].i, q[0].r, 64'(dw_idx), 64'(q[0].i));
                check(last_beat == q[0].l, "R8", 64'(last_beat), 64'(q[0].l));
                if (beat_adv) void'(q.pop_front());
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; exp_linear = 1'b0; exp_locked = 1'b0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic boot(input bit lin, input bit l2);
        boot_linear = lin; l2_present = l2; boot_load = 1'b1;
        if (!exp_locked) begin
            exp_linear = lin && l2;
            exp_locked = 1'b1;
        end
        tick();
        boot_load = 1'b0;
    endtask

    // Driver: push expected beats, then run the transfer with some stalls
    task automatic xfer(input bit wr, input bit b8, input logic [AW-1:0] a,
                        input bit poke, input string req);
        int            len = b8 ? 8 : 4;
        int            lb  = b8 ? 6 : 5;
        logic [2:0]    st  = 3'(a[5:3] & 3'(len - 1));
        bit            lin = wr || exp_linear;
        logic [AW-1:0] ea  = lin ? (a & ~((AW'(1) << lb) - 1)) : (a & ~AW'(7));
        for (int n = 0; n < len; n++) begin
            item_t it;
            it.a = ea;
            it.i = lin ? 3'(n) : 3'(st ^ 3'(n));
            it.l = (n == len - 1);
            it.r = req;
            q.push_back(it);
        end
        req_write = wr; req_blk8 = b8; req_addr = a; req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
        // R11: busy one cycle after acceptance
        check(busy == 1'b1, "R11", 64'(busy), 64'd1);
        for (int n = 0; n < len; n++) begin
            if (n % 3 == 1) begin
                beat_adv = 1'b0;
                if (poke) begin
                    req_valid = 1'b1; req_write = ~wr; req_blk8 = ~b8;
                    req_addr = a ^ 32'h0000_0FF8;
                end
                tick();
                req_valid = 1'b0;
            end
            beat_adv = 1'b1;
            tick();
        end
        beat_adv = 1'b0;
        check(busy == 1'b0, "R8", 64'(busy), 64'd0);
        check(q.size() == 0, req, 64'(q.size()), 64'd0);
        tick();
        check(busy == 1'b0, "R9", 64'(busy), 64'd0);
    endtask

    initial begin
        do_reset();
        #1;
        // R1 reset state
        check(busy == 1'b0, "R1", 64'(busy), 64'd0);
        check(last_beat == 1'b0, "R1", 64'(last_beat), 64'd0);
        check(dw_idx == 3'd0, "R1", 64'(dw_idx), 64'd0);
        check(bus_addr == '0, "R1", 64'(bus_addr), 64'd0);
        // R1: interleaved before any boot load
        xfer(1'b0, 1'b0, 32'h0000_0118, 1'b0, "R1");

        // Linear boot, then an ignored second load (R2)
        boot(1'b1, 1'b1);
        boot(1'b0, 1'b1);
        xfer(1'b0, 1'b1, 32'h1000_0028, 1'b0, "R5");
        xfer(1'b0, 1'b0, 32'h2000_003C, 1'b0, "R2");
        xfer(1'b1, 1'b0, 32'h3000_0038, 1'b0, "R4");
        xfer(1'b1, 1'b1, 32'h3000_07F0, 1'b0, "R7");

        // Linear requested without secondary cache: interleaved (R3)
        do_reset();
        boot(1'b1, 1'b0);
        xfer(1'b0, 1'b1, 32'h4000_0028, 1'b0, "R3");
        xfer(1'b0, 1'b0, 32'h4000_003C, 1'b0, "R6");
        xfer(1'b0, 1'b1, 32'h4000_0078, 1'b1, "R9");
        xfer(1'b1, 1'b1, 32'h5000_0068, 1'b0, "R4");

        // Interleaved by choice, stalls exercise R10
        do_reset();
        boot(1'b0, 1'b1);
        boot(1'b1, 1'b1);
        xfer(1'b0, 1'b0, 32'h6000_0010, 1'b1, "R10");
        xfer(1'b0, 1'b1, 32'h6000_0000, 1'b0, "R6");
        xfer(1'b1, 1'b0, 32'h6000_0011, 1'b1, "R7");

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            vectors++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule